// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block decides which of two reference clocks, A or B, drives downstream logic. It does not detect clock loss and it does not switch the clocks. Two status inputs report a lost clock for each reference, and a glitch-free clock multiplexer elsewhere acts on the select that this block produces. A small configuration register holds a priority bit and a two-bit mode field. The priority bit names the primary reference. The mode field picks manual selection, automatic failover that stays on the backup, or automatic failover that returns to the primary.

In the automatic modes the controller leaves the primary as soon as the primary is lost and the other reference is present. In the returning mode, the primary must then be seen present on a set number of consecutive clock cycles (status samples) before the controller goes back to it. That number comes from the `revert_samples` input. When both references are lost the controller holds its choice and raises a flag. Every change of the select produces a pulse one cycle wide.

Top module: `clk_switchover_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `sel_b` goes to 0, `switch_pulse` and `both_lost` go to 0, and the configuration register goes to mode 11 (automatic, returning) with the priority bit at 0.
- R2: A priority bit of 0 makes reference A the primary. A priority bit of 1 makes reference B the primary. `sel_b` = 0 selects A and 1 selects B.
- R3: A write (`cfg_we` high at an edge) loads the mode and the priority bit. The new values control the decision from the next edge on. Mode 00 or 01 is manual, 10 is automatic staying and 11 is automatic returning.
- R4: In manual mode `sel_b` takes the value of `man_sel_b` at each edge, whatever the loss inputs show.
- R5: In either automatic mode, while the primary is selected, an edge at which the primary is lost and the secondary is present moves `sel_b` to the secondary.
- R6: In returning mode, while the secondary is selected, the controller returns to the primary at the edge where the primary has been sampled present on `revert_samples` consecutive edges, counting that edge. A value of 0 acts as 1. One lost sample restarts the count.
- R7: In staying mode, while the secondary is selected and present, the select stays on the secondary however long the primary has been present.
- R8: In an automatic mode, an edge at which both references are lost leaves `sel_b` unchanged. In every mode `both_lost` shows, one edge later, whether both loss inputs were high.
- R9: `switch_pulse` is high for exactly the cycle after each edge at which `sel_b` changes, and low otherwise.
- R10: In either automatic mode, while the secondary is selected, an edge at which the secondary is lost and the primary is present moves `sel_b` back to the primary without waiting for the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the loss inputs are sampled on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the mode and priority fields |
| cfg_mode | input | 2 | Mode to load (0x manual, 10 staying, 11 returning) |
| cfg_prim_b | input | 1 | Priority bit to load (0: A primary, 1: B primary) |
| lost_a | input | 1 | Reference A is lost |
| lost_b | input | 1 | Reference B is lost |
| man_sel_b | input | 1 | Manual select (0: A, 1: B) |
| revert_samples | input | CNT_W | Consecutive present samples needed before returning to the primary |
| sel_b | output | 1 | Active reference (0: A, 1: B), registered |
| switch_pulse | output | 1 | One-cycle pulse after each change of `sel_b` |
| both_lost | output | 1 | Both references were lost at the previous edge |

## Verification
The bench builds the block with the default `CNT_W` of 8 and drives `revert_samples` only from 0 to 4. This keeps every return delay within a few cycles, so a long pseudo-random run reaches the full and the interrupted return counts many times. The same run also crosses every mode, both priority settings, configuration writes in every state, and all four loss combinations. Directed sequences first set up each transition the requirements name: failover, return after exactly N samples, staying on the backup, holding under double loss, and manual override under loss.

// File: rtl/swo_pkg.sv
package swo_pkg;

  typedef enum logic [1:0] {
    MODE_MAN_0 = 2'b00,
    MODE_MAN_1 = 2'b01,
    MODE_STAY  = 2'b10,
    MODE_RET   = 2'b11
  } swo_mode_e;

  typedef struct packed {
    swo_mode_e mode;
    logic      prim_b;
  } swo_cfg_t;

  localparam swo_cfg_t SWO_CFG_RST = '{mode: MODE_RET, prim_b: 1'b0};

  function automatic logic mode_is_auto(swo_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_ret(swo_mode_e m);
    return m == MODE_RET;
  endfunction

endpackage

// File: rtl/swo_cfg_reg.sv
module swo_cfg_reg
  import swo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] wmode,
  input  logic       wprim_b,
  output swo_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= SWO_CFG_RST;
    end else if (we) begin
      cfg.mode   <= swo_mode_e'(wmode);
      cfg.prim_b <= wprim_b;
    end
  end

endmodule

// File: rtl/swo_revert_timer.sv
module swo_revert_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EXT_W-1:0] cnt_inc;
  logic [EXT_W-1:0] lim_eff;

  always_comb begin
    cnt_inc = {1'b0, cnt} + EXT_W'(1);
    lim_eff = (limit == '0) ? EXT_W'(1) : {1'b0, limit};
    fire    = en && (cnt_inc >= lim_eff);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || fire) cnt <= '0;
    else                    cnt <= cnt_inc[CNT_W-1:0];
  end

  logic chk_ok;
  always_ff @(posedge clk) chk_ok <= !rst;

  // R6: a sample counted on one edge means the window was open on that edge
  a_r6_count_needs_window: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    (cnt != '0) |-> $past(en));

endmodule

// File: rtl/swo_select_fsm.sv
module swo_select_fsm
  import swo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  swo_cfg_t cfg,
  input  logic     lost_a,
  input  logic     lost_b,
  input  logic     man_sel_b,
  input  logic     fire,
  output logic     tmr_en,
  output logic     sel_b,
  output logic     switch_pulse,
  output logic     both_lost
);

  logic lost_pri, lost_sec, on_sec, both, nxt_sel;

  always_comb begin
    lost_pri = cfg.prim_b ? lost_b : lost_a;
    lost_sec = cfg.prim_b ? lost_a : lost_b;
    on_sec   = (sel_b != cfg.prim_b);
    both     = lost_a && lost_b;
    tmr_en   = mode_is_ret(cfg.mode) && on_sec && !lost_pri;
    nxt_sel  = sel_b;
    if (!mode_is_auto(cfg.mode)) begin
      nxt_sel = man_sel_b;
    end else if (both) begin
      nxt_sel = sel_b;
    end else if (!on_sec) begin
      if (lost_pri && !lost_sec) nxt_sel = !cfg.prim_b;
    end else begin
      if ((lost_sec && !lost_pri) || fire) nxt_sel = cfg.prim_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_b        <= 1'b0;
      switch_pulse <= 1'b0;
      both_lost    <= 1'b0;
    end else begin
      sel_b        <= nxt_sel;
      switch_pulse <= (nxt_sel != sel_b);
      both_lost    <= both;
    end
  end

  logic chk_ok;
  always_ff @(posedge clk) chk_ok <= !rst;

  a_r9_pulse_marks_change: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    switch_pulse == (sel_b != $past(sel_b)));

  a_r4_manual_follows: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(!mode_is_auto(cfg.mode)) |-> sel_b == $past(man_sel_b));

  a_r8_both_lost_holds: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(mode_is_auto(cfg.mode) && lost_a && lost_b) |-> $stable(sel_b));

  a_r5_failover: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(mode_is_auto(cfg.mode) && !on_sec && lost_pri && !lost_sec) |-> sel_b != $past(sel_b));

  a_r7_stay_on_backup: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(cfg.mode == MODE_STAY && on_sec && !lost_sec) |-> $stable(sel_b));

  a_r10_backup_lost: assert property (@(posedge clk) disable iff (rst || !chk_ok)
    $past(mode_is_auto(cfg.mode) && on_sec && lost_sec && !lost_pri) |-> sel_b == $past(cfg.prim_b));

endmodule

// File: rtl/clk_switchover_ctrl.sv
module clk_switchover_ctrl
  import swo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_prim_b,
  input  logic             lost_a,
  input  logic             lost_b,
  input  logic             man_sel_b,
  input  logic [CNT_W-1:0] revert_samples,
  output logic             sel_b,
  output logic             switch_pulse,
  output logic             both_lost
);

  swo_cfg_t cfg;
  logic     tmr_en;
  logic     tmr_fire;

  swo_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wmode   (cfg_mode),
    .wprim_b (cfg_prim_b),
    .cfg     (cfg)
  );

  swo_revert_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .en    (tmr_en),
    .limit (revert_samples),
    .fire  (tmr_fire)
  );

  swo_select_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cfg          (cfg),
    .lost_a       (lost_a),
    .lost_b       (lost_b),
    .man_sel_b    (man_sel_b),
    .fire         (tmr_fire),
    .tmr_en       (tmr_en),
    .sel_b        (sel_b),
    .switch_pulse (switch_pulse),
    .both_lost    (both_lost)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!sel_b && !switch_pulse && !both_lost));

endmodule

// File: tb/clk_switchover_ctrl_test.sv
`timescale 1ns/1ps
module clk_switchover_ctrl_test;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_prim_b = 1'b0;
  logic lost_a = 1'b0, lost_b = 1'b0, man_sel_b = 1'b0;
  logic [CNT_W-1:0] revert_samples = '0;
  logic sel_b, switch_pulse, both_lost;

  int n_run = 0, n_fail = 0;

  // reference model state
  logic [1:0] m_mode;
  logic m_prim, m_sel, m_pulse, m_both;
  int m_cnt;
  string m_tag;

  always #2 clk = ~clk;

  clk_switchover_ctrl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_prim_b(cfg_prim_b),
    .lost_a(lost_a), .lost_b(lost_b), .man_sel_b(man_sel_b), .revert_samples(revert_samples),
    .sel_b(sel_b), .switch_pulse(switch_pulse), .both_lost(both_lost)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Model one edge from the requirements, using the inputs now applied.
  task automatic model_step();
    logic lp, ls, onsec, en, fire, nxt;
    int lim;
    lp = m_prim ? lost_b : lost_a;
    ls = m_prim ? lost_a : lost_b;
    onsec = (m_sel != m_prim);
    en = (m_mode == 2'b11) && onsec && !lp;
    lim = (revert_samples == 0) ? 1 : int'(revert_samples);
    fire = en && (m_cnt + 1 >= lim);
    nxt = m_sel;
    if (!m_mode[1]) begin nxt = man_sel_b; m_tag = "R4"; end
    else if (lost_a && lost_b) m_tag = "R8";
    else if (!onsec) begin
      m_tag = "R5";
      if (lp && !ls) nxt = !m_prim;
    end else if (ls && !lp) begin nxt = m_prim; m_tag = "R10"; end
    else if (fire) begin nxt = m_prim; m_tag = "R6"; end
    else m_tag = (m_mode == 2'b10) ? "R7" : "R6";
    m_cnt = en ? (fire ? 0 : m_cnt + 1) : 0;
    m_pulse = (nxt != m_sel);
    m_sel = nxt;
    m_both = lost_a && lost_b;
    if (cfg_we) begin m_mode = cfg_mode; m_prim = cfg_prim_b; end
  endtask

  // Called at a falling edge with inputs set: one rising edge, then compare.
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(m_tag, sel_b, m_sel);
    check("R9", switch_pulse, m_pulse);
    check("R8", both_lost, m_both);
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] md, input logic pb);
    cfg_we = 1'b1; cfg_mode = md; cfg_prim_b = pb;
    cyc();
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_mode = 2'b11; m_prim = 1'b0; m_sel = 1'b0; m_pulse = 1'b0; m_both = 1'b0; m_cnt = 0;
    // R1: reset state
    check("R1", sel_b, 1'b0);
    check("R1", switch_pulse, 1'b0);
    check("R1", both_lost, 1'b0);

    // R1/R5: default mode is returning with A primary; lose A
    revert_samples = 8'd3;
    lost_a = 1'b1; cyc();
    check("R5", sel_b, 1'b1);
    check("R9", switch_pulse, 1'b1);
    // R6: return after exactly 3 present samples
    lost_a = 1'b0; cyc(); cyc();
    check("R6", sel_b, 1'b1);
    cyc();
    check("R6", sel_b, 1'b0);
    // R6: interrupted count restarts
    lost_a = 1'b1; cyc();
    lost_a = 1'b0; cyc(); cyc();
    lost_a = 1'b1; cyc();
    lost_a = 1'b0; cyc(); cyc();
    check("R6", sel_b, 1'b1);
    cyc();
    check("R6", sel_b, 1'b0);

    // R3/R7: staying mode keeps backup
    wr(2'b10, 1'b0);
    lost_a = 1'b1; cyc();
    check("R5", sel_b, 1'b1);
    lost_a = 1'b0;
    repeat (20) cyc();
    check("R7", sel_b, 1'b1);
    // R10: backup lost, primary present
    lost_b = 1'b1; cyc();
    check("R10", sel_b, 1'b0);
    // R8: both lost holds and flags
    lost_a = 1'b1; cyc();
    check("R8", sel_b, 1'b0);
    check("R8", both_lost, 1'b1);
    lost_a = 1'b0; lost_b = 1'b0; cyc();

    // R2: B primary, returning mode, N=0 acts as 1
    revert_samples = 8'd0;
    wr(2'b11, 1'b1);
    cyc();
    check("R2", sel_b, 1'b1);
    lost_b = 1'b1; cyc();
    check("R2", sel_b, 1'b0);
    lost_b = 1'b0; cyc();
    check("R6", sel_b, 1'b1);

    // R4: manual follows select, ignores loss
    wr(2'b00, 1'b1);
    man_sel_b = 1'b0; lost_a = 1'b1; cyc();
    check("R4", sel_b, 1'b0);
    man_sel_b = 1'b1; lost_a = 1'b0; lost_b = 1'b1; cyc();
    check("R4", sel_b, 1'b1);
    wr(2'b01, 1'b0);
    man_sel_b = 1'b0; cyc();
    check("R3", sel_b, 1'b0);
    lost_b = 1'b0;

    // Sweep: pseudo-random stimulus against the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 20000; i++) begin
      seed = xs(seed);
      if (seed[3:0] == 4'd0) lost_a = ~lost_a;
      if (seed[7:4] == 4'd0) lost_b = ~lost_b;
      man_sel_b = seed[8];
      if (seed[14:9] == 6'd0) revert_samples = CNT_W'(seed[17:15] % 5);
      cfg_we = (seed[23:18] == 6'd0);
      cfg_mode = seed[25:24];
      cfg_prim_b = seed[26];
      cyc();
    end

    finish_run();
  end

endmodule